// File: doc/BRIEF.md
# AES-128 Encryption Core with Selector-Keyed Substitution

This core encrypts one 128-bit block with a ten-round AES-128 flow and completes one round per clock. It keeps the standard round order and round count. The only change is in SubBytes: every substitution result is the standard S-box entry XORed with an 8-bit selector byte, which the surrounding system derives from the key. A selector of zero gives standard AES-128.

The core does not expand keys. It drives a round-key index and reads the matching 128-bit round key back in the same cycle from an external key store. That store must hold its contents steady while a block is in flight. A one-cycle start strobe captures the plaintext and the selector. One cycle-wide valid strobe then presents the ciphertext, which is held until the next result.

Top module: `dsb_aes_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` is 0, `ct_o` is all zeros and `rk_idx_o` is 0.
- R2: In the cycle `start_i` is accepted, `rk_idx_o` is 0 and the plaintext is XORed with that key. In the ten following cycles `rk_idx_o` reads 1, 2, … 10, and then it returns to 0.
- R3: For a start accepted in cycle k, `valid_o` is high in cycle k+11 only, and stays low in the other cycles of that run.
- R4: `ct_o` equals the ten-round encryption of the captured plaintext under the supplied round keys. It changes only in a cycle where `valid_o` is high.
- R5: With selector 0x00, the core gives the standard AES-128 ciphertext. For key 000102…0f and plaintext 00112233…eeff it gives 69c4e0d86a7b0430d8cdb78070b4c55a. For an all-zero key and plaintext it gives 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R6: Rounds 1 to 9 apply substitution, row rotation, column mix and key XOR, in that order. Round 10 skips the column mix.
- R7: A start strobe during rounds 1 to 10 is ignored. It produces no extra valid and does not alter the result in flight.
- R8: Plaintext and selector are captured at start. Changing `pt_i` or `sel_i` later in the run has no effect on that result.
- R9: A start in the same cycle that `valid_o` is high is accepted and begins a new run.
- R10: Byte i of the state occupies bits [127-8i -: 8]. Its row is i mod 4 and its column is i/4. Row r is rotated left by r byte positions.
- R11: Substitution maps byte x to S(x) XOR selector, where S is the standard AES S-box: the GF(2^8) inverse modulo 0x11B followed by the affine map with constant 0x63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin encrypting `pt_i` (ignored while busy) |
| pt_i | input | 128 | Plaintext block |
| sel_i | input | 8 | Key-derived substitution selector |
| rk_i | input | 128 | Round key for the index on `rk_idx_o` |
| rk_idx_o | output | 4 | Round-key index being read |
| ct_o | output | 128 | Ciphertext, held between results |
| valid_o | output | 1 | One-cycle strobe marking a new ciphertext |

## Verification
Two things can happen in the same cycle: the output stage finishing one block and the control launching the next. To provoke this, the bench raises `start_i` exactly in the cycle where `valid_o` is high. In that cycle the index must already read 0 for the new block's initial key XOR, while the old ciphertext is presented. The bench then judges both results against its reference model, together with their arrival cycles, k+11 and k+22. A second overlap case is a start raised while a block is in rounds 1 to 10. The bench judges that case by counting valid strobes and by checking that the result in flight is unchanged.

// File: rtl/dsb_aes_pkg.sv
package dsb_aes_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BLK_W / BYTE_W;
    localparam int NCOLS  = 4;
    localparam int NROWS  = NBYTES / NCOLS;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;
    localparam logic [BYTE_W-1:0] AFF_C    = 8'h63;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BLK_W-1:0]  block_t;

    function automatic byte_t gf_dbl(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // x^254 equals the multiplicative inverse (and maps 0 to 0)
    function automatic byte_t gf_inv(input byte_t a);
        byte_t res  = 8'h01;
        byte_t base = a;
        logic [7:0] ex = 8'd254;
        for (int i = 0; i < BYTE_W; i++) begin
            if (ex[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t aff_map(input byte_t b);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ AFF_C;
    endfunction

endpackage

// File: rtl/dsb_sbox.sv
module dsb_sbox
    import dsb_aes_pkg::*;
(
    input  logic [BYTE_W-1:0] in_i,
    input  logic [BYTE_W-1:0] sel_i,
    output logic [BYTE_W-1:0] out_o
);
    logic [BYTE_W-1:0] inv_w;

    always_comb begin
        inv_w = gf_inv(in_i);
        out_o = aff_map(inv_w) ^ sel_i;
    end
endmodule

// File: rtl/dsb_mixcol.sv
module dsb_mixcol
    import dsb_aes_pkg::*;
#(
    parameter int COL_W = NROWS * BYTE_W
) (
    input  logic [COL_W-1:0] col_i,
    output logic [COL_W-1:0] col_o
);
    localparam int NR = COL_W / BYTE_W;

    logic [BYTE_W-1:0] a [NR];
    logic [BYTE_W-1:0] y [NR];

    always_comb begin
        for (int r = 0; r < NR; r++) a[r] = col_i[COL_W-1-BYTE_W*r -: BYTE_W];
        for (int r = 0; r < NR; r++) begin
            // row r of the circulant (2 3 1 1) rotated right by r
            y[r] = gf_dbl(a[r])
                 ^ gf_dbl(a[(r+1)%NR]) ^ a[(r+1)%NR]
                 ^ a[(r+2)%NR]
                 ^ a[(r+3)%NR];
        end
        for (int r = 0; r < NR; r++) col_o[COL_W-1-BYTE_W*r -: BYTE_W] = y[r];
    end
endmodule

// File: rtl/dsb_round.sv
module dsb_round
    import dsb_aes_pkg::*;
(
    input  logic [BLK_W-1:0]  st_i,
    input  logic [BYTE_W-1:0] sel_i,
    input  logic [BLK_W-1:0]  rk_i,
    input  logic              last_i,
    output logic [BLK_W-1:0]  st_o
);
    localparam int COL_W = NROWS * BYTE_W;

    logic [BLK_W-1:0] sub_w;
    logic [BLK_W-1:0] shf_w;
    logic [BLK_W-1:0] mix_w;

    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_sub
            dsb_sbox u_sbox (
                .in_i  (st_i [BLK_W-1-BYTE_W*gi -: BYTE_W]),
                .sel_i (sel_i),
                .out_o (sub_w[BLK_W-1-BYTE_W*gi -: BYTE_W])
            );
        end
    endgenerate

    always_comb begin
        for (int c = 0; c < NCOLS; c++) begin
            for (int r = 0; r < NROWS; r++) begin
                shf_w[BLK_W-1-BYTE_W*(r+NROWS*c) -: BYTE_W] =
                    sub_w[BLK_W-1-BYTE_W*(r+NROWS*((c+r)%NCOLS)) -: BYTE_W];
            end
        end
    end

    generate
        for (gi = 0; gi < NCOLS; gi++) begin : g_mix
            dsb_mixcol #(.COL_W(COL_W)) u_mix (
                .col_i (shf_w[BLK_W-1-COL_W*gi -: COL_W]),
                .col_o (mix_w[BLK_W-1-COL_W*gi -: COL_W])
            );
        end
    endgenerate

    assign st_o = (last_i ? shf_w : mix_w) ^ rk_i;
endmodule

// File: rtl/dsb_aes_enc.sv
module dsb_aes_enc
    import dsb_aes_pkg::*;
#(
    parameter int NRND = 10,
    parameter int RK_W = $clog2(NRND + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  pt_i,
    input  logic [BYTE_W-1:0] sel_i,
    input  logic [BLK_W-1:0]  rk_i,
    output logic [RK_W-1:0]   rk_idx_o,
    output logic [BLK_W-1:0]  ct_o,
    output logic              valid_o
);
    localparam logic [RK_W-1:0] LAST_RND = RK_W'(NRND);

    typedef struct packed {
        logic              busy;
        logic [RK_W-1:0]   rnd;
        logic [BYTE_W-1:0] sel;
        logic [BLK_W-1:0]  st;
        logic [BLK_W-1:0]  ct;
        logic              vld;
    } core_t;

    core_t c_d, c_q;
    logic [BLK_W-1:0] rnd_out_w;
    logic             last_w;

    assign last_w = (c_q.rnd == LAST_RND);

    dsb_round u_round (
        .st_i   (c_q.st),
        .sel_i  (c_q.sel),
        .rk_i   (rk_i),
        .last_i (last_w),
        .st_o   (rnd_out_w)
    );

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        if (!c_q.busy) begin
            if (start_i) begin
                c_d.st   = pt_i ^ rk_i;
                c_d.sel  = sel_i;
                c_d.rnd  = RK_W'(1);
                c_d.busy = 1'b1;
            end
        end else begin
            c_d.st = rnd_out_w;
            if (last_w) begin
                c_d.busy = 1'b0;
                c_d.rnd  = '0;
                c_d.ct   = rnd_out_w;
                c_d.vld  = 1'b1;
            end else begin
                c_d.rnd = c_q.rnd + RK_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign rk_idx_o = c_q.busy ? c_q.rnd : '0;
    assign ct_o     = c_q.ct;
    assign valid_o  = c_q.vld;
endmodule

// File: rtl/dsb_aes_enc_chk.sv
module dsb_aes_enc_chk #(
    parameter int NRND = 10,
    parameter int RK_W = $clog2(NRND + 1)
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic [RK_W-1:0] rk_idx_o,
    input logic [127:0]    ct_o,
    input logic            valid_o
);
    localparam logic [RK_W-1:0] LASTI = RK_W'(NRND);

    // R2
    rk_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_idx_o == '0 && start_i) |=> rk_idx_o == RK_W'(1));
    // R2
    rk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_idx_o != '0 && rk_idx_o != LASTI) |=> rk_idx_o == $past(rk_idx_o) + RK_W'(1));
    // R3
    rk_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_idx_o == LASTI) |=> (rk_idx_o == '0 && valid_o));
    // R3
    valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(rk_idx_o) == LASTI);
    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_idx_o == '0 && !start_i) |=> (rk_idx_o == '0 && !valid_o));
    // R4
    ct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> $stable(ct_o));
endmodule

bind dsb_aes_enc dsb_aes_enc_chk #(.NRND(NRND), .RK_W(RK_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .rk_idx_o (rk_idx_o),
    .ct_o     (ct_o),
    .valid_o  (valid_o)
);

// File: tb/tb_dsb_aes_enc.sv
module tb_dsb_aes_enc;
    logic         clk = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] pt_i = '0;
    logic [7:0]   sel_i = '0;
    logic [127:0] rk_i;
    logic [3:0]   rk_idx_o;
    logic [127:0] ct_o;
    logic         valid_o;

    always #4 clk = ~clk;

    dsb_aes_enc dut (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pt_i(pt_i),
        .sel_i(sel_i), .rk_i(rk_i), .rk_idx_o(rk_idx_o), .ct_o(ct_o),
        .valid_o(valid_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, n_vld = 0;
    bit done = 0;
    logic [7:0]   sb [256];
    logic [127:0] rk_tab [11];

    typedef struct { logic [127:0] ct; int scyc; string tag; } exp_t;
    exp_t sbq [$];

    always @(posedge clk) cyc <= cyc + 1;
    always_comb rk_i = (rk_idx_o <= 4'd10) ? rk_tab[rk_idx_o] : '0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // standard S-box from the generator walk (3 and its inverse)
    task automatic build_sbox();
        logic [7:0] p = 8'h01, q = 8'h01, x;
        do begin
            p = p ^ xt(p);
            q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    task automatic set_key(input logic [127:0] k);
        logic [31:0] w [44];
        logic [7:0] rc = 8'h01;
        logic [31:0] t;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = xt(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [7:0] sel);
        logic [7:0] s [16], u [16], a0, a1, a2, a3;
        logic [127:0] st = pt ^ rk_tab[0];
        for (int r = 1; r <= 10; r++) begin
            for (int i = 0; i < 16; i++) u[i] = sb[st[127-8*i -: 8]] ^ sel;
            for (int i = 0; i < 16; i++) s[i] = u[(i%4) + 4*(((i/4) + (i%4)) % 4)];
            if (r < 10) begin
                for (int c = 0; c < 4; c++) begin
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
            end
            for (int i = 0; i < 16; i++) st[127-8*i -: 8] = s[i];
            st = st ^ rk_tab[r];
        end
        return st;
    endfunction

    // driver: caller sits at a negedge; start is high for this cycle
    task automatic launch(input logic [127:0] pt, input logic [7:0] sel,
                          input logic [127:0] exp, input string tag);
        exp_t e;
        e.ct = exp; e.scyc = cyc; e.tag = tag;
        sbq.push_back(e);
        pt_i = pt; sel_i = sel; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_ni && valid_o && !done) begin
            exp_t e;
            n_vld++;
            if (sbq.size() == 0) begin
                chk(1'b0, "R7 unexpected valid", 128'(cyc), 128'(0));
            end else begin
                e = sbq.pop_front();
                chk(ct_o == e.ct, e.tag, ct_o, e.ct);
                chk(cyc == e.scyc + 11, "R3 valid cycle", 128'(cyc), 128'(e.scyc + 11));
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int v0;
        logic [127:0] e;
        build_sbox();
        set_key('0);
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0 && ct_o == '0 && rk_idx_o == '0, "R1 reset state",
            {ct_o[123:0], rk_idx_o}, '0);
        rst_ni = 1'b1;
        @(negedge clk);
        chk(valid_o == 1'b0 && ct_o == '0 && rk_idx_o == '0, "R1 after reset",
            {ct_o[123:0], rk_idx_o}, '0);

        // R5 standard vectors with selector 0
        set_key(128'h000102030405060708090a0b0c0d0e0f);
        launch(128'h00112233445566778899aabbccddeeff, 8'h00,
               128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5 kat vector 1");
        repeat (12) @(negedge clk);
        set_key('0);
        launch('0, 8'h00, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R5 kat zero");
        repeat (12) @(negedge clk);

        // R2 index sequence, R11/R6 with a nonzero selector
        set_key(128'h6172726167736c696d616e5f6d697469);
        e = ref_enc(128'h68616d646f756e5f265f747261676861, 8'h61);
        chk(rk_idx_o == 4'd0, "R2 index idle at start", 128'(rk_idx_o), 128'd0);
        launch(128'h68616d646f756e5f265f747261676861, 8'h61, e, "R11 sel 61");
        for (int r = 1; r <= 10; r++) begin
            chk(rk_idx_o == 4'(r), "R2 index step", 128'(rk_idx_o), 128'(r));
            @(negedge clk);
        end
        chk(rk_idx_o == 4'd0, "R2 index back to 0", 128'(rk_idx_o), 128'd0);
        repeat (2) @(negedge clk);

        // R4/R6/R10/R11 several selectors and patterns
        for (int k = 0; k < 4; k++) begin
            logic [7:0] s8 = (k == 0) ? 8'h24 : (k == 1) ? 8'h6f : (k == 2) ? 8'hff : 8'h35;
            logic [127:0] p = {4{32'h01234567 ^ (32'h9e3779b9 * (k + 1))}};
            launch(p, s8, ref_enc(p, s8), "R4 R6 R10 R11 model match");
            repeat (11) @(negedge clk);
        end

        // R7: start while busy is ignored
        v0 = n_vld;
        launch(128'hdeadbeef00000000cafef00d12345678, 8'h3c,
               ref_enc(128'hdeadbeef00000000cafef00d12345678, 8'h3c), "R7 result in flight");
        repeat (3) @(negedge clk);
        pt_i = '1; sel_i = 8'h11; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        chk(n_vld == v0 + 1, "R7 single valid", 128'(n_vld), 128'(v0 + 1));
        chk(rk_idx_o == 4'd0, "R7 idle after", 128'(rk_idx_o), 128'd0);

        // R8: inputs changed mid-run
        launch(128'h00000000000000000000000000000001, 8'h5a,
               ref_enc(128'h00000000000000000000000000000001, 8'h5a), "R8 captured inputs");
        repeat (2) @(negedge clk);
        pt_i = 128'hffff0000ffff0000ffff0000ffff0000; sel_i = 8'ha5;
        repeat (12) @(negedge clk);

        // R9: start coincides with valid
        launch(128'h0f0e0d0c0b0a09080706050403020100, 8'h81,
               ref_enc(128'h0f0e0d0c0b0a09080706050403020100, 8'h81), "R9 first block");
        repeat (10) @(negedge clk);
        chk(valid_o == 1'b1, "R9 valid in launch cycle", 128'(valid_o), 128'd1);
        launch(128'h123456789abcdef00fedcba987654321, 8'h00,
               ref_enc(128'h123456789abcdef00fedcba987654321, 8'h00), "R9 second block");
        repeat (14) @(negedge clk);

        chk(sbq.size() == 0, "R3 all results seen", 128'(sbq.size()), 128'd0);
        finish_up();
    end
endmodule